// File: doc/BRIEF.md
# Backplane Slave Address Decoder with Block Address Tracking

This block sits on the slave side of an asynchronous parallel backplane bus. When the active-low address strobe falls, it captures a 6-bit address-modifier code and the 32-bit address. It turns the code into three things: an address space (16, 24 or 32 significant bits), a privilege level (supervisor or user) and an access kind (data, program or block). The significant address bits above the window size are compared with a configured base. When the code is valid, the address hits the window and the privilege is allowed, the block raises a select. The select is held until the address strobe is released.

While selected, every data strobe produces an acknowledge request. A block transfer has only one address phase. During a block transfer the block keeps its own copy of the address within the window and steps it after each acknowledged data strobe. The step is 4 bytes for 32-bit data and 2 bytes for 16-bit data. The address lines are not sampled again until the next address phase. The local address output gives the offset inside the window, which a memory or register file behind the decoder can use.

The strobes are assumed to be already synchronised to `clk` by the surrounding logic. Every edge of a strobe is seen one clock after it is sampled.

Top module: `bp_slave_decoder`

## Requirements
- R1: While reset is held and at the first clock after it is released, `sel` and `ack_req` are 0 and `loc_addr` is 0.
- R2: `am` and `addr` are captured on the first rising clock edge at which `as_n` is sampled low after being high. `sel` takes its decoded value right after that edge. Changes on `am` and `addr` while `as_n` stays low have no effect on `sel`, and in a non-block cycle they have no effect on `loc_addr`.
- R3: Only the following codes (hex) are valid. Block codes: 3F and 0F (supervisor), 3B and 0B (user). Program codes: 3E and 0E (supervisor), 3A and 0A (user). Data codes: 3D and 0D (supervisor), 39 and 09 (user). The 16-bit codes are 2D (supervisor) and 29 (user). Codes 3x are 24-bit, 0x are 32-bit and 2x are 16-bit. Any other code never raises `sel` or `ack_req`.
- R4: The window compare uses only the bits from `WIN_BITS` up to the top significant bit. For 32-bit codes that is bit 31, for 24-bit codes bit 23 and for 16-bit codes bit 15. Any mismatch in those bits leaves `sel` low, and the bits above them are ignored.
- R5: When `cfg_user_dis` is 1, a user-level code leaves `sel` low even if it hits the window. Supervisor codes are not affected.
- R6: `ack_req` is 1 in the cycle after `ds_n` is sampled low while `sel` is 1 and `as_n` is low. It returns to 0 right after the edge at which `ds_n` is sampled high again. It is never 1 while `sel` is 0.
- R7: In a block-code cycle, `loc_addr` increases by 4 (`wide_xfer`=1) or by 2 (`wide_xfer`=0) modulo 2^`WIN_BITS` after each acknowledged data strobe is released. In program and data cycles it does not change.
- R8: `sel` returns to 0 right after the first edge at which `as_n` is sampled high.
- R9: Right after the capture edge, `loc_addr` equals the low `WIN_BITS` bits of the captured address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| as_n | input | 1 | Address strobe, active low, already synchronised |
| ds_n | input | 1 | Data strobe, active low, already synchronised |
| am | input | 6 | Address-modifier code |
| addr | input | 32 | Bus address |
| cfg_base | input | 32 | Window base address (bits below WIN_BITS ignored) |
| cfg_user_dis | input | 1 | 1 = refuse user-level codes |
| wide_xfer | input | 1 | 1 = 32-bit data beats, 0 = 16-bit |
| sel | output | 1 | Slave selected for the current address cycle |
| ack_req | output | 1 | Request to acknowledge the current data strobe |
| loc_addr | output | WIN_BITS | Offset within the window, stepped in block cycles |

## Verification
The assertions assume that the strobes change only between clock edges and are already synchronised. They also assume that `ds_n` falls only while `as_n` is low, and that `wide_xfer` and `cfg_user_dis` are steady for the duration of an address cycle. The bench drives every input on the falling clock edge. It opens a data strobe only after the address strobe has been low for at least one clock edge. It changes the configuration only while `as_n` is high. It also drives inverted address and code values during the data phases, so that the latching behaviour is exercised without breaking those assumptions.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

  localparam int ADDR_W = 32;
  localparam int AM_W   = 6;

  typedef enum logic [1:0] {SPC_A16, SPC_A24, SPC_A32, SPC_NONE} space_e;
  typedef enum logic [1:0] {KND_DATA, KND_PROG, KND_BLOCK, KND_NONE} kind_e;

  typedef struct packed {
    logic   valid;
    logic   priv;
    space_e space;
    kind_e  kind;
  } am_info_t;

  // Bit layout of the code: [5:4] space group, [3] must be 1,
  // [2] supervisor flag, [1:0] kind (01 data, 10 program, 11 block).
  function automatic am_info_t am_classify(input logic [AM_W-1:0] code);
    am_info_t r;
    r.valid = 1'b0;
    r.priv  = code[2];
    r.space = SPC_NONE;
    r.kind  = KND_NONE;
    if (code[3] && code[1:0] != 2'b00) begin
      unique case (code[5:4])
        2'b11: begin r.space = SPC_A24; r.valid = 1'b1; end
        2'b00: begin r.space = SPC_A32; r.valid = 1'b1; end
        2'b10: begin
          if (code[1:0] == 2'b01) begin
            r.space = SPC_A16;
            r.valid = 1'b1;
          end
        end
        default: r.valid = 1'b0;
      endcase
      if (r.valid) begin
        unique case (code[1:0])
          2'b01:   r.kind = KND_DATA;
          2'b10:   r.kind = KND_PROG;
          default: r.kind = KND_BLOCK;
        endcase
      end
    end
    return r;
  endfunction

  function automatic int unsigned space_bits(input space_e s);
    unique case (s)
      SPC_A16: return 16;
      SPC_A24: return 24;
      default: return 32;
    endcase
  endfunction

  // Ones on the significant bits at or above the window size.
  function automatic logic [ADDR_W-1:0] cmp_mask(input space_e s, input int unsigned wb);
    logic [ADDR_W:0] top;
    logic [ADDR_W:0] low;
    top = ({{ADDR_W{1'b0}}, 1'b1} << space_bits(s)) - 1'b1;
    low = ({{ADDR_W{1'b0}}, 1'b1} << wb) - 1'b1;
    top = top & ~low;
    return top[ADDR_W-1:0];
  endfunction

  function automatic logic [2:0] beat_bytes(input logic wide);
    return wide ? 3'd4 : 3'd2;
  endfunction

endpackage

// File: rtl/bsd_am_decode.sv
module bsd_am_decode
  import bsd_pkg::*;
(
  input  logic [AM_W-1:0] code,
  output am_info_t        info
);
  always_comb info = am_classify(code);
endmodule

// File: rtl/bsd_window.sv
module bsd_window
  import bsd_pkg::*;
#(
  parameter int WIN_BITS = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  space_e            space,
  output logic              hit
);
  logic [ADDR_W-1:0] mask;
  always_comb begin
    mask = cmp_mask(space, WIN_BITS);
    hit  = (space != SPC_NONE) && (((addr ^ base) & mask) == '0);
  end
endmodule

// File: rtl/bsd_blk_track.sv
module bsd_blk_track
  import bsd_pkg::*;
#(
  parameter int WIN_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [WIN_BITS-1:0] load_val,
  input  logic                adv,
  input  logic                wide,
  output logic [WIN_BITS-1:0] cur
);
  logic [WIN_BITS-1:0] step;
  always_comb step = WIN_BITS'(beat_bytes(wide));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cur <= '0;
    else if (load) cur <= load_val;
    else if (adv)  cur <= cur + step;
  end
endmodule

// File: rtl/bp_slave_decoder.sv
module bp_slave_decoder
  import bsd_pkg::*;
#(
  parameter int WIN_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                as_n,
  input  logic                ds_n,
  input  logic [5:0]          am,
  input  logic [31:0]         addr,
  input  logic [31:0]         cfg_base,
  input  logic                cfg_user_dis,
  input  logic                wide_xfer,
  output logic                sel,
  output logic                ack_req,
  output logic [WIN_BITS-1:0] loc_addr
);
  logic     as_q, ds_q;
  logic     as_fall, ds_rise;
  am_info_t info;
  logic     am_valid, am_priv;
  logic     win_hit, accept;
  logic     sel_q, blk_q, ack_q;
  logic     adv_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_q <= 1'b1;
      ds_q <= 1'b1;
    end else begin
      as_q <= as_n;
      ds_q <= ds_n;
    end
  end

  always_comb begin
    as_fall = as_q & ~as_n;
    ds_rise = ~ds_q & ds_n;
  end

  bsd_am_decode u_dec (.code(am), .info(info));

  bsd_window #(.WIN_BITS(WIN_BITS)) u_win (
    .addr(addr), .base(cfg_base), .space(info.space), .hit(win_hit)
  );

  always_comb begin
    am_valid = info.valid;
    am_priv  = info.priv;
    accept   = am_valid & win_hit & (am_priv | ~cfg_user_dis);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      blk_q <= 1'b0;
    end else if (as_n) begin
      sel_q <= 1'b0;
      blk_q <= 1'b0;
    end else if (as_fall) begin
      sel_q <= accept;
      blk_q <= accept && (info.kind == KND_BLOCK);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= sel_q & ~ds_n & ~as_n;
  end

  always_comb adv_evt = ds_rise & ack_q & blk_q & ~as_n;

  bsd_blk_track #(.WIN_BITS(WIN_BITS)) u_trk (
    .clk(clk), .rst_n(rst_n), .load(as_fall), .load_val(addr[WIN_BITS-1:0]),
    .adv(adv_evt), .wide(wide_xfer), .cur(loc_addr)
  );

  assign sel     = sel_q;
  assign ack_req = ack_q;
endmodule

// File: rtl/bsd_checker.sv
module bsd_checker #(
  parameter int WIN_BITS = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                as_n,
  input logic                sel,
  input logic                ack_req,
  input logic [WIN_BITS-1:0] loc_addr,
  input logic                wide_xfer,
  input logic                cfg_user_dis,
  input logic                as_fall,
  input logic                adv_evt,
  input logic                am_valid,
  input logic                am_priv,
  input logic                blk_q
);
  AST_ACK_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> sel); // R6
  AST_SEL_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    sel |-> !$past(as_n)); // R8
  AST_INVALID_UNSEL: assert property (@(posedge clk) disable iff (!rst_n)
    (as_fall && !am_valid) |=> !sel); // R3
  AST_USER_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (as_fall && cfg_user_dis && !am_priv) |=> !sel); // R5
  AST_ADV_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |-> (blk_q && sel)); // R7
  AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |=> (WIN_BITS'(loc_addr - $past(loc_addr)) ==
                 WIN_BITS'($past(wide_xfer) ? 4 : 2))); // R7
  AST_LOC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_evt && !as_fall) |=> $stable(loc_addr)); // R2
endmodule

bind bp_slave_decoder bsd_checker #(.WIN_BITS(WIN_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .as_n(as_n), .sel(sel), .ack_req(ack_req),
  .loc_addr(loc_addr), .wide_xfer(wide_xfer), .cfg_user_dis(cfg_user_dis),
  .as_fall(as_fall), .adv_evt(adv_evt), .am_valid(am_valid),
  .am_priv(am_priv), .blk_q(blk_q)
);

// File: tb/bp_slave_decoder_tb.sv
module bp_slave_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WB = 12;
  localparam logic [31:0] BASE = 32'hA5C3_7000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic as_n = 1'b1, ds_n = 1'b1;
  logic [5:0] am = '0;
  logic [31:0] addr = '0;
  logic cfg_user_dis = 1'b0, wide_xfer = 1'b0;
  logic sel, ack_req;
  logic [WB-1:0] loc_addr;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bp_slave_decoder #(.WIN_BITS(WB)) u_dut (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .ds_n(ds_n), .am(am), .addr(addr),
    .cfg_base(BASE), .cfg_user_dis(cfg_user_dis), .wide_xfer(wide_xfer),
    .sel(sel), .ack_req(ack_req), .loc_addr(loc_addr)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Independent model of the valid code list.
  task automatic model(input logic [5:0] c, output bit v, output bit pr,
                       output int w, output bit blk);
    v = 1; blk = 0; pr = 0; w = 0;
    case (c)
      6'h3F: begin w = 24; pr = 1; blk = 1; end
      6'h3E: begin w = 24; pr = 1; end
      6'h3D: begin w = 24; pr = 1; end
      6'h3B: begin w = 24; blk = 1; end
      6'h3A: w = 24;
      6'h39: w = 24;
      6'h0F: begin w = 32; pr = 1; blk = 1; end
      6'h0E: begin w = 32; pr = 1; end
      6'h0D: begin w = 32; pr = 1; end
      6'h0B: begin w = 32; blk = 1; end
      6'h0A: w = 32;
      6'h09: w = 32;
      6'h2D: begin w = 16; pr = 1; end
      6'h29: w = 16;
      default: v = 0;
    endcase
  endtask

  task automatic run(input logic [5:0] c, input logic [31:0] a, input bit ud, input bit wd);
    bit v, pr, blk, hit, es;
    int w, nds, step;
    longint diff;
    string tag;
    model(c, v, pr, w, blk);
    hit = 0;
    if (v) begin
      diff = longint'((a ^ BASE) >> WB);
      hit = (diff % (longint'(1) << (w - WB))) == 0;
    end
    es = v && hit && (pr || !ud);
    if (!v) tag = "R3";
    else if (!hit) tag = "R4";
    else if (!pr && ud) tag = "R5";
    else tag = "R2";
    nds = blk ? 3 : 2;
    step = wd ? 4 : 2;
    @(negedge clk);
    am = c; addr = a; cfg_user_dis = ud; wide_xfer = wd;
    @(negedge clk);
    as_n = 1'b0;
    @(negedge clk);
    chk(sel == es, tag, sel, es);
    if (es) chk(loc_addr == a[WB-1:0], "R9", loc_addr, a[WB-1:0]);
    addr = ~a; am = ~c;
    for (int b = 0; b < nds; b++) begin
      ds_n = 1'b0;
      @(negedge clk);
      chk(ack_req == es, "R6", ack_req, es);
      ds_n = 1'b1;
      @(negedge clk);
      chk(ack_req == 1'b0, "R6", ack_req, 0);
      chk(sel == es, "R2", sel, es);
      if (es) begin
        logic [WB-1:0] el;
        el = WB'(a[WB-1:0] + (blk ? (b + 1) * step : 0));
        chk(loc_addr == el, "R7", loc_addr, el);
      end
    end
    as_n = 1'b1;
    @(negedge clk);
    chk(sel == 1'b0, "R8", sel, 0);
  endtask

  initial begin
    automatic int timeout = 0;
    while (timeout < 150000) begin
      @(posedge clk);
      timeout++;
    end
    checks++; failures++;
    $display("FAIL watchdog actual=%0d expected=done", timeout);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] variants [9];
    variants[0] = BASE | 32'h0000_0123;
    variants[1] = BASE | 32'h0000_0FFC;
    variants[2] = (BASE | 32'h0000_0040) ^ 32'h0000_1000;
    variants[3] = BASE ^ 32'h0000_8000;
    variants[4] = BASE ^ 32'h0001_0000;
    variants[5] = BASE ^ 32'h0080_0000;
    variants[6] = BASE ^ 32'h0100_0000;
    variants[7] = (BASE | 32'h0000_0FFE) ^ 32'h8000_0000;
    variants[8] = (BASE | 32'h0000_0002) ^ 32'h00F3_0000;
    repeat (3) @(negedge clk);
    chk(sel == 0 && ack_req == 0, "R1", {sel, ack_req}, 0);
    chk(loc_addr == 0, "R1", loc_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sel == 0 && ack_req == 0 && loc_addr == 0, "R1", {sel, ack_req, loc_addr}, 0);
    for (int c = 0; c < 64; c++)
      for (int i = 0; i < 9; i++)
        for (int u = 0; u < 2; u++)
          run(6'(c), variants[i], u[0], c[0] ^ u[0] ^ i[0]);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule